// File: doc/BRIEF.md
# Branch Target and Decision Unit

This unit resolves control transfer for a 64-bit processor, one instruction per accepted transaction. Each transaction carries a decoded transfer kind, a raw 26-bit immediate field, a 4-bit condition selector, the N/Z/C/V flags, a register operand, a 6-bit bit index, the link register value and the PC of the instruction. The unit returns the next PC, a taken flag, an optional link-register write of the return address, and an optional destination-register write for the two PC-relative address-forming kinds.

Transactions enter on a valid/ready input and leave on a valid/ready output through a single output register. An input beat is accepted on a rising edge when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. When `out_valid` is high and `out_ready` is low, every output holds its value and no new beat is taken. A synchronous active-high reset empties the output register, clears the flags and write enables, and loads `out_next_pc` from `rst_vec`.

Top module: `brn_resolve_unit`

## Requirements
- R1: Kind codes are 0 B, 1 BL, 2 conditional, 3 CBZ, 4 CBNZ, 5 TBZ, 6 TBNZ, 7 BR, 8 BLR, 9 RET, 10 ADR, 11 ADRP. A taken PC-relative branch gives PC + 4 × sign-extended immediate. The immediate is in_imm[25:0] for B/BL, in_imm[18:0] for conditional, CBZ and CBNZ, and in_imm[13:0] for TBZ/TBNZ.
- R2: A conditional branch is taken by selector (flags are in_flags[3]=N, [2]=Z, [1]=C, [0]=V): 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !(C&!Z), 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 its inverse. Selectors 14 and 15 always take the branch.
- R3: CBZ is taken when in_rn is zero and CBNZ when it is non-zero.
- R4: TBZ is taken when in_rn[in_bit] is 0 and TBNZ when it is 1, for any index from 0 to 63.
- R5: BL and BLR raise out_lr_we with out_lr_data = PC+4 in the same beat as the redirect. No other kind raises out_lr_we.
- R6: BR and BLR jump to in_rn. RET jumps to in_rn when in_rn_given is 1, and otherwise to in_lr. All three set out_taken.
- R7: ADR raises out_rd_we with out_rd_data = PC + sign-extended in_imm[20:0]. It is not taken and the next PC is PC+4.
- R8: ADRP raises out_rd_we with out_rd_data = (PC with bits 11:0 cleared) + (sign-extended in_imm[20:0] << 12). Bits 11:0 of the result are zero. It is not taken.
- R9: A beat that takes no branch, including kinds 12 to 15, gives out_next_pc = PC+4, out_taken = 0 and out_lr_we = 0. out_rd_we is 0 for every kind except ADR and ADRP.
- R10: in_ready is low while out_valid is high and out_ready is low. During such a stall all outputs hold their values.
- R11: Reset gives out_valid = 0, out_taken = 0, out_lr_we = 0, out_rd_we = 0 and out_next_pc = rst_vec.
- R12: in_imm bits above the width that a kind uses have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rst_vec | input | 64 | Value loaded into out_next_pc at reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Unit can take an input beat |
| in_kind | input | 4 | Transfer kind code |
| in_imm | input | 26 | Raw immediate field |
| in_cond | input | 4 | Condition selector |
| in_flags | input | 4 | N, Z, C, V from bit 3 to bit 0 |
| in_rn | input | 64 | Register operand |
| in_rn_given | input | 1 | RET uses in_rn instead of in_lr |
| in_bit | input | 6 | Bit index for test-bit branches |
| in_lr | input | 64 | Current link register value |
| in_pc | input | 64 | PC of the instruction |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result beat |
| out_next_pc | output | 64 | Resolved next PC |
| out_taken | output | 1 | Transfer taken |
| out_lr_we | output | 1 | Link register write enable |
| out_lr_data | output | 64 | Return address |
| out_rd_we | output | 1 | Destination register write enable |
| out_rd_data | output | 64 | ADR/ADRP result |

## Verification
Every result is due exactly one rising edge after its input beat is accepted. It stays visible until the edge on which out_valid and out_ready are both high. The bench queues expected results in acceptance order and drives inputs and out_ready just after the falling edge. One unit after that, it compares the head of the queue against the outputs whenever a handover will occur at the coming edge. When the previous sample was a stall, it compares the outputs against that sample. The reference takes the in_ready it sees as the acceptance condition for the next beat, so a lost or duplicated beat shows up as a mismatch in the queue.

// File: rtl/brn_pkg.sv
package brn_pkg;

  // Width of the raw immediate field carried with every beat
  localparam int FLD_W   = 26;
  // Width of the address-forming immediate and the page shift
  localparam int ADR_W   = 21;
  localparam int PAGE_SH = 12;
  // Number of PC-relative branch immediate variants
  localparam int N_BRW   = 3;

  typedef enum logic [3:0] {
    BK_B     = 4'd0,
    BK_BL    = 4'd1,
    BK_BCOND = 4'd2,
    BK_CBZ   = 4'd3,
    BK_CBNZ  = 4'd4,
    BK_TBZ   = 4'd5,
    BK_TBNZ  = 4'd6,
    BK_BR    = 4'd7,
    BK_BLR   = 4'd8,
    BK_RET   = 4'd9,
    BK_ADR   = 4'd10,
    BK_ADRP  = 4'd11
  } brn_kind_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } brn_flags_t;

  // Branch immediate widths: 0 = long jump, 1 = medium, 2 = short
  function automatic int brw(input int idx);
    case (idx)
      0:       return 26;
      1:       return 19;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/brn_cond_eval.sv
module brn_cond_eval
  import brn_pkg::*;
(
  input  logic [3:0] cond,
  input  brn_flags_t flags,
  output logic       pass
);

  logic base;
  logic inv;

  always_comb begin
    case (cond[3:1])
      3'd0:    base = flags.z;
      3'd1:    base = flags.c;
      3'd2:    base = flags.n;
      3'd3:    base = flags.v;
      3'd4:    base = flags.c & ~flags.z;
      3'd5:    base = (flags.n == flags.v);
      3'd6:    base = ~flags.z & (flags.n == flags.v);
      default: base = 1'b1;
    endcase
  end

  // The last pair is always taken: no inversion for it
  assign inv  = cond[0] & (cond[3:1] != 3'd7);
  assign pass = base ^ inv;

endmodule

// File: rtl/brn_target_gen.sv
module brn_target_gen
  import brn_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0]  pc,
  input  logic [FLD_W-1:0] imm,
  output logic [XLEN-1:0]  seq_pc,
  output logic [XLEN-1:0]  br_tgt [N_BRW],
  output logic [XLEN-1:0]  adr_res,
  output logic [XLEN-1:0]  adrp_res
);

  localparam int STEP = 4;
  localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

  assign seq_pc = pc + STEP_V;

  // One sign-extended, word-scaled target per branch immediate width
  for (genvar g = 0; g < N_BRW; g++) begin : g_brw
    localparam int W = brw(g);
    logic [XLEN-1:0] off;
    assign off       = {{(XLEN-W-2){imm[W-1]}}, imm[W-1:0], 2'b00};
    assign br_tgt[g] = pc + off;
  end

  logic [XLEN-1:0] adr_off;
  logic [XLEN-1:0] page_off;
  logic [XLEN-1:0] page_base;
  logic [XLEN-1:0] page_sum;

  assign adr_off   = {{(XLEN-ADR_W){imm[ADR_W-1]}}, imm[ADR_W-1:0]};
  assign adr_res   = pc + adr_off;

  assign page_off  = {{(XLEN-ADR_W-PAGE_SH){imm[ADR_W-1]}}, imm[ADR_W-1:0], {PAGE_SH{1'b0}}};
  assign page_base = {pc[XLEN-1:PAGE_SH], {PAGE_SH{1'b0}}};
  assign page_sum  = page_base + page_off;
  assign adrp_res  = {page_sum[XLEN-1:PAGE_SH], {PAGE_SH{1'b0}}};

endmodule

// File: rtl/brn_decide.sv
module brn_decide
  import brn_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [3:0]              kind,
  input  logic                    cond_pass,
  input  logic [XLEN-1:0]         rn,
  input  logic                    rn_given,
  input  logic [$clog2(XLEN)-1:0] bit_idx,
  input  logic [XLEN-1:0]         lr,
  input  logic [XLEN-1:0]         seq_pc,
  input  logic [XLEN-1:0]         br_tgt [N_BRW],
  input  logic [XLEN-1:0]         adr_res,
  input  logic [XLEN-1:0]         adrp_res,
  output logic [XLEN-1:0]         next_pc,
  output logic                    taken,
  output logic                    lr_we,
  output logic                    rd_we,
  output logic [XLEN-1:0]         rd_data
);

  logic            rn_zero;
  logic            rn_bit;
  logic [XLEN-1:0] cand;

  assign rn_zero = (rn == '0);
  assign rn_bit  = rn[bit_idx];

  always_comb begin
    taken   = 1'b0;
    cand    = seq_pc;
    lr_we   = 1'b0;
    rd_we   = 1'b0;
    rd_data = '0;
    case (brn_kind_e'(kind))
      BK_B:     begin taken = 1'b1;      cand = br_tgt[0]; end
      BK_BL:    begin taken = 1'b1;      cand = br_tgt[0]; lr_we = 1'b1; end
      BK_BCOND: begin taken = cond_pass; cand = br_tgt[1]; end
      BK_CBZ:   begin taken = rn_zero;   cand = br_tgt[1]; end
      BK_CBNZ:  begin taken = ~rn_zero;  cand = br_tgt[1]; end
      BK_TBZ:   begin taken = ~rn_bit;   cand = br_tgt[2]; end
      BK_TBNZ:  begin taken = rn_bit;    cand = br_tgt[2]; end
      BK_BR:    begin taken = 1'b1;      cand = rn; end
      BK_BLR:   begin taken = 1'b1;      cand = rn; lr_we = 1'b1; end
      BK_RET:   begin taken = 1'b1;      cand = rn_given ? rn : lr; end
      BK_ADR:   begin rd_we = 1'b1;      rd_data = adr_res; end
      BK_ADRP:  begin rd_we = 1'b1;      rd_data = adrp_res; end
      default:  ;
    endcase
  end

  assign next_pc = taken ? cand : seq_pc;

endmodule

// File: rtl/brn_resolve_unit.sv
module brn_resolve_unit
  import brn_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [XLEN-1:0]         rst_vec,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [3:0]              in_kind,
  input  logic [FLD_W-1:0]        in_imm,
  input  logic [3:0]              in_cond,
  input  logic [3:0]              in_flags,
  input  logic [XLEN-1:0]         in_rn,
  input  logic                    in_rn_given,
  input  logic [$clog2(XLEN)-1:0] in_bit,
  input  logic [XLEN-1:0]         in_lr,
  input  logic [XLEN-1:0]         in_pc,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [XLEN-1:0]         out_next_pc,
  output logic                    out_taken,
  output logic                    out_lr_we,
  output logic [XLEN-1:0]         out_lr_data,
  output logic                    out_rd_we,
  output logic [XLEN-1:0]         out_rd_data
);

  logic            c_pass;
  logic [XLEN-1:0] c_seq;
  logic [XLEN-1:0] c_tgt [N_BRW];
  logic [XLEN-1:0] c_adr;
  logic [XLEN-1:0] c_adrp;
  logic [XLEN-1:0] c_next;
  logic            c_taken;
  logic            c_lr_we;
  logic            c_rd_we;
  logic [XLEN-1:0] c_rd_data;
  logic            accept;

  brn_cond_eval u_cond (
    .cond  (in_cond),
    .flags (brn_flags_t'(in_flags)),
    .pass  (c_pass)
  );

  brn_target_gen #(.XLEN(XLEN)) u_tgt (
    .pc       (in_pc),
    .imm      (in_imm),
    .seq_pc   (c_seq),
    .br_tgt   (c_tgt),
    .adr_res  (c_adr),
    .adrp_res (c_adrp)
  );

  brn_decide #(.XLEN(XLEN)) u_dec (
    .kind      (in_kind),
    .cond_pass (c_pass),
    .rn        (in_rn),
    .rn_given  (in_rn_given),
    .bit_idx   (in_bit),
    .lr        (in_lr),
    .seq_pc    (c_seq),
    .br_tgt    (c_tgt),
    .adr_res   (c_adr),
    .adrp_res  (c_adrp),
    .next_pc   (c_next),
    .taken     (c_taken),
    .lr_we     (c_lr_we),
    .rd_we     (c_rd_we),
    .rd_data   (c_rd_data)
  );

  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_next_pc <= rst_vec;
      out_taken   <= 1'b0;
      out_lr_we   <= 1'b0;
      out_lr_data <= '0;
      out_rd_we   <= 1'b0;
      out_rd_data <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (accept) begin
        out_next_pc <= c_next;
        out_taken   <= c_taken;
        out_lr_we   <= c_lr_we;
        out_lr_data <= c_seq;
        out_rd_we   <= c_rd_we;
        out_rd_data <= c_rd_data;
      end
    end
  end

endmodule

// File: rtl/brn_resolve_chk.sv
module brn_resolve_chk
  import brn_pkg::*;
#(
  parameter int XLEN = 64
) (
  input logic             clk,
  input logic             rst,
  input logic [XLEN-1:0]  rst_vec,
  input logic             in_valid,
  input logic             in_ready,
  input logic [3:0]       in_kind,
  input logic [XLEN-1:0]  in_pc,
  input logic             out_valid,
  input logic             out_ready,
  input logic [XLEN-1:0]  out_next_pc,
  input logic             out_taken,
  input logic             out_lr_we,
  input logic [XLEN-1:0]  out_lr_data,
  input logic             out_rd_we,
  input logic [XLEN-1:0]  out_rd_data
);

  localparam logic [XLEN-1:0] STEP_V = XLEN'(4);

  // Shadow of the PC and kind of the beat held in the output register
  logic [XLEN-1:0] held_pc;
  logic [3:0]      held_kind;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_pc   <= '0;
      held_kind <= '0;
    end else if (in_valid && in_ready) begin
      held_pc   <= in_pc;
      held_kind <= in_kind;
    end
  end

  // R11
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_taken && !out_lr_we && !out_rd_we && out_next_pc == $past(rst_vec)));

  // R10
  stall_blocks_input_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  // R10
  stall_holds_output_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_next_pc) && $stable(out_taken)
                                   && $stable(out_lr_we) && $stable(out_rd_we) && $stable(out_rd_data)));

  // R5
  link_value_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_lr_we) |-> (out_taken && out_lr_data == held_pc + STEP_V));

  // R9
  fallthrough_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_taken) |-> (out_next_pc == held_pc + STEP_V && !out_lr_we));

  // R7
  addr_form_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_rd_we) |-> (!out_taken && !out_lr_we));

  // R8
  page_align_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_rd_we && held_kind == BK_ADRP) |-> (out_rd_data[11:0] == 12'd0));

  // R9
  rd_kind_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_rd_we) |-> (held_kind == BK_ADR || held_kind == BK_ADRP));

endmodule

bind brn_resolve_unit brn_resolve_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .rst_vec     (rst_vec),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_kind     (in_kind),
  .in_pc       (in_pc),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_next_pc (out_next_pc),
  .out_taken   (out_taken),
  .out_lr_we   (out_lr_we),
  .out_lr_data (out_lr_data),
  .out_rd_we   (out_rd_we),
  .out_rd_data (out_rd_data)
);

// File: tb/brn_resolve_unit_tb.sv
module brn_resolve_unit_tb;

  typedef struct {
    logic [3:0]  kind;
    logic [25:0] imm;
    logic [3:0]  cond;
    logic [3:0]  flags;
    logic [63:0] rn;
    logic        given;
    logic [5:0]  bidx;
    logic [63:0] lr;
    logic [63:0] pc;
    int          tag;
  } stim_t;

  typedef struct {
    logic [63:0] npc;
    logic        taken;
    logic        lr_we;
    logic [63:0] lr_data;
    logic        rd_we;
    logic [63:0] rd_data;
    int          tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] rst_vec = 64'hFFFF_0000_0000_1000;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_kind = '0;
  logic [25:0] in_imm = '0;
  logic [3:0]  in_cond = '0;
  logic [3:0]  in_flags = '0;
  logic [63:0] in_rn = '0;
  logic        in_rn_given = 1'b0;
  logic [5:0]  in_bit = '0;
  logic [63:0] in_lr = '0;
  logic [63:0] in_pc = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_next_pc;
  logic        out_taken;
  logic        out_lr_we;
  logic [63:0] out_lr_data;
  logic        out_rd_we;
  logic [63:0] out_rd_data;

  int checks = 0;
  int errors = 0;
  stim_t sq[$];
  exp_t  eq[$];

  always #5 clk = ~clk;

  brn_resolve_unit u_dut (
    .clk(clk), .rst(rst), .rst_vec(rst_vec),
    .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind), .in_imm(in_imm),
    .in_cond(in_cond), .in_flags(in_flags), .in_rn(in_rn), .in_rn_given(in_rn_given),
    .in_bit(in_bit), .in_lr(in_lr), .in_pc(in_pc),
    .out_valid(out_valid), .out_ready(out_ready), .out_next_pc(out_next_pc),
    .out_taken(out_taken), .out_lr_we(out_lr_we), .out_lr_data(out_lr_data),
    .out_rd_we(out_rd_we), .out_rd_data(out_rd_data)
  );

  task automatic chk64(input int tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Signed value of the low w bits of a field
  function automatic logic [63:0] sfield(input logic [25:0] f, input int w);
    longint v = 0;
    for (int i = 0; i < w; i++) v[i] = f[i];
    if (f[w-1]) v = v - (longint'(1) <<< w);
    return v;
  endfunction

  function automatic logic cond_ok(input logic [3:0] c, input logic [3:0] fl);
    logic n, z, cc, v;
    {n, z, cc, v} = fl;
    case (c)
      0: return z;              1: return !z;
      2: return cc;             3: return !cc;
      4: return n;              5: return !n;
      6: return v;              7: return !v;
      8: return cc && !z;       9: return !(cc && !z);
      10: return n == v;        11: return n != v;
      12: return !z && n == v;  13: return !(!z && n == v);
      default: return 1'b1;
    endcase
  endfunction

  function automatic exp_t model(input stim_t s);
    exp_t e;
    logic tk = 1'b0;
    logic [63:0] dest = 64'd0;
    e.lr_we = 1'b0; e.rd_we = 1'b0; e.rd_data = 64'd0; e.tag = s.tag;
    e.lr_data = s.pc + 64'd4;
    case (s.kind)
      0, 1: begin tk = 1; dest = s.pc + (sfield(s.imm, 26) << 2); e.lr_we = (s.kind == 1); end
      2: begin tk = cond_ok(s.cond, s.flags); dest = s.pc + (sfield(s.imm, 19) << 2); end
      3: begin tk = (s.rn == 0); dest = s.pc + (sfield(s.imm, 19) << 2); end
      4: begin tk = (s.rn != 0); dest = s.pc + (sfield(s.imm, 19) << 2); end
      5: begin tk = !s.rn[s.bidx]; dest = s.pc + (sfield(s.imm, 14) << 2); end
      6: begin tk = s.rn[s.bidx]; dest = s.pc + (sfield(s.imm, 14) << 2); end
      7, 8: begin tk = 1; dest = s.rn; e.lr_we = (s.kind == 8); end
      9: begin tk = 1; dest = s.given ? s.rn : s.lr; end
      10: begin e.rd_we = 1; e.rd_data = s.pc + sfield(s.imm, 21); end
      11: begin
        e.rd_we = 1;
        e.rd_data = (s.pc & ~64'hFFF) + (sfield(s.imm, 21) * 64'd4096);
      end
      default: ;
    endcase
    e.taken = tk;
    e.npc = tk ? dest : s.pc + 64'd4;
    return e;
  endfunction

  task automatic add(input int tag, input logic [3:0] k, input logic [25:0] imm,
                     input logic [63:0] rn, input logic [63:0] pc);
    stim_t s;
    s.kind = k; s.imm = imm; s.cond = 4'($urandom); s.flags = 4'($urandom);
    s.rn = rn; s.given = 1'($urandom); s.bidx = 6'($urandom);
    s.lr = {$urandom, $urandom}; s.pc = pc; s.tag = tag;
    sq.push_back(s);
  endtask

  initial begin : stim_build
    stim_t s;
    // R1: long jump both directions, medium and short widths at their extremes
    add(1, 4'd0, 26'd5, 64'd0, 64'h0000_0040_0000_1000);
    add(1, 4'd0, 26'h3FF_FFFF, 64'd0, 64'h0000_0040_0000_1000);
    add(1, 4'd0, 26'h200_0000, 64'd0, 64'h0000_0100_0000_0000);
    add(1, 4'd3, 26'h004_0000, 64'd0, 64'h0000_0000_8000_0000);
    add(1, 4'd6, 26'h000_2000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0001_0000);
    // R2: every selector against every flag combination
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 16; f++) begin
        s.kind = 4'd2; s.imm = 26'($urandom) & 26'h7FFFF; s.cond = 4'(c); s.flags = 4'(f);
        s.rn = 64'd0; s.given = 1'b0; s.bidx = 6'd0; s.lr = 64'd0;
        s.pc = {32'd0, $urandom} & ~64'd3; s.tag = 2;
        sq.push_back(s);
      end
    // R3: zero, one and the top bit alone
    add(3, 4'd3, 26'd8, 64'd0, 64'h1000);
    add(3, 4'd3, 26'd8, 64'd1, 64'h1000);
    add(3, 4'd4, 26'd8, 64'd0, 64'h1000);
    add(3, 4'd4, 26'h7FFFF, 64'h8000_0000_0000_0000, 64'h1000);
    // R4: bit 0, bit 63, middle bit with negative short offsets
    for (int b = 0; b < 64; b += 21) begin
      s.kind = 4'd5; s.imm = 26'h3FFF; s.cond = 0; s.flags = 0; s.rn = 64'd1 << b;
      s.given = 0; s.bidx = 6'(b); s.lr = 0; s.pc = 64'h2000; s.tag = 4; sq.push_back(s);
      s.kind = 4'd6; sq.push_back(s);
      s.bidx = 6'(b + 1); sq.push_back(s);
    end
    s.kind = 4'd6; s.rn = 64'h8000_0000_0000_0000; s.bidx = 6'd63; s.imm = 26'h2000; sq.push_back(s);
    s.kind = 4'd5; s.rn = 64'd2; s.bidx = 6'd0; s.imm = 26'h1; sq.push_back(s);
    // R5: calls with immediate and register targets
    add(5, 4'd1, 26'h3FF_FFF0, 64'd0, 64'h0000_0055_5555_07CC);
    add(5, 4'd8, 26'd0, 64'h0000_0055_5555_0774, 64'h0000_0055_5555_07CC);
    // R6: register jump and return with and without a supplied register
    add(6, 4'd7, 26'd0, 64'hDEAD_BEEF_0000_0010, 64'h3000);
    s.kind = 4'd9; s.imm = 0; s.cond = 0; s.flags = 0; s.rn = 64'hAAAA_0000_0000_0004;
    s.bidx = 0; s.lr = 64'h0000_0055_5555_07D0; s.pc = 64'h4000; s.tag = 6;
    s.given = 1'b0; sq.push_back(s);
    s.given = 1'b1; sq.push_back(s);
    // R7: address forming at the positive and negative range limits
    add(7, 4'd10, 26'h00F_FFFF, 64'd0, 64'h0000_0000_1234_5678);
    add(7, 4'd10, 26'h010_0000, 64'd0, 64'h0000_0000_1234_5678);
    // R8: page form with a PC that has low bits set
    add(8, 4'd11, 26'h000_0003, 64'd0, 64'h0000_0000_1234_5ABC);
    add(8, 4'd11, 26'h01F_FFFF, 64'd0, 64'h0000_0000_1234_5FFC);
    // R9: unused kinds fall through
    for (int k = 12; k < 16; k++) add(9, 4'(k), 26'($urandom), 64'd0, 64'h5000);
    // R12: junk above each kind's immediate width
    add(12, 4'd2, 26'h3F8_0001, 64'd0, 64'h6000);
    add(12, 4'd3, 26'h2A8_0004, 64'd0, 64'h6000);
    add(12, 4'd5, 26'h3FF_C002, 64'd0, 64'h6000);
    add(12, 4'd10, 26'h3E0_0010, 64'd0, 64'h6000);
    add(12, 4'd11, 26'h3E0_0001, 64'd0, 64'h6000);
    // Random mix across all kinds (R1 group)
    for (int i = 0; i < 300; i++)
      add(1, 4'($urandom_range(0, 15)), 26'($urandom), {$urandom, $urandom},
          {$urandom, $urandom} & ~64'd3);
  end

  initial begin : run
    int cyc = 0;
    logic stalled = 1'b0;
    logic [63:0] h_npc = 0, h_rd = 0;
    logic h_tk = 0, h_lr = 0, h_rdwe = 0;
    exp_t e;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk64(11, "out_valid", 64'(out_valid), 64'd0);
    chk64(11, "out_next_pc", out_next_pc, rst_vec);
    chk64(11, "out_taken", 64'(out_taken), 64'd0);
    chk64(11, "out_lr_we", 64'(out_lr_we), 64'd0);
    chk64(11, "out_rd_we", 64'(out_rd_we), 64'd0);
    rst = 1'b0;
    while ((sq.size() > 0 || eq.size() > 0) && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      out_ready = ($urandom_range(0, 9) < 7);
      #1;
      if (stalled) begin
        // R10: held outputs during a stall
        chk64(10, "held valid", 64'(out_valid), 64'd1);
        chk64(10, "held next_pc", out_next_pc, h_npc);
        chk64(10, "held taken/lr/rd", {61'd0, out_taken, out_lr_we, out_rd_we}, {61'd0, h_tk, h_lr, h_rdwe});
        chk64(10, "held rd_data", out_rd_data, h_rd);
      end
      if (out_valid && !out_ready) chk64(10, "in_ready in stall", 64'(in_ready), 64'd0);
      if (out_valid && out_ready) begin
        if (eq.size() == 0) begin
          chk64(10, "unexpected beat", 64'd1, 64'd0);
        end else begin
          e = eq.pop_front();
          chk64(e.tag, "next_pc", out_next_pc, e.npc);
          chk64(e.tag, "taken", 64'(out_taken), 64'(e.taken));
          chk64(e.tag, "lr_we", 64'(out_lr_we), 64'(e.lr_we));
          if (e.lr_we) chk64(e.tag, "lr_data", out_lr_data, e.lr_data);
          chk64(e.tag, "rd_we", 64'(out_rd_we), 64'(e.rd_we));
          if (e.rd_we) chk64(e.tag, "rd_data", out_rd_data, e.rd_data);
        end
      end
      stalled = out_valid && !out_ready;
      h_npc = out_next_pc; h_tk = out_taken; h_lr = out_lr_we; h_rdwe = out_rd_we; h_rd = out_rd_data;
      if (in_ready && sq.size() > 0 && $urandom_range(0, 9) < 8) begin
        stim_t s;
        s = sq.pop_front();
        in_valid = 1'b1; in_kind = s.kind; in_imm = s.imm; in_cond = s.cond;
        in_flags = s.flags; in_rn = s.rn; in_rn_given = s.given; in_bit = s.bidx;
        in_lr = s.lr; in_pc = s.pc;
        eq.push_back(model(s));
      end else begin
        in_valid = 1'b0;
      end
    end
    if (cyc >= 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired with %0d beats outstanding", eq.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule